// File: doc/BRIEF.md
# Falling-Edge Phase Comparator with Lock Qualifier

This block sits in a motor speed loop. It watches two slow square waves: a reference clock that sets the target rate, and the speed feedback pulse train from the motor. Only the high-to-low transition of each wave counts. When the reference falls first, the motor is behind, and the block raises a pump-up pulse. That pulse lasts until the feedback falls. When the feedback falls first, the motor is ahead, and a pump-down pulse runs until the next reference fall. A downstream loop filter turns the pulse duty into a torque command. As the loop settles, the feedback rate comes to equal the reference rate. The pulse direction also appears as a two-bit code for a three-state driver: source, sink or released.

Both inputs pass through a parameterised synchronizer. A falling edge is taken from the synchronized value. The pulse engine is a three-state machine:
- `PH_IDLE`: no measurement is open.
- `PH_LAG`: the reference edge was seen and the block waits for the feedback edge.
- `PH_LEAD`: the feedback edge was seen and the block waits for the reference edge.

Its transitions are:
- start-lag: IDLE to LAG on a lone reference edge.
- start-lead: IDLE to LEAD on a lone feedback edge.
- coincide: IDLE stays IDLE when both edges arrive together.
- close: LAG or LEAD returns to IDLE on the awaited edge.
- close-and-reopen: LAG stays LAG when both edges arrive together, and LEAD stays LEAD when both arrive together.
- slip: LAG or LEAD stays put on a second edge of its own starting input.
- halt: any state goes to IDLE when disabled.

Each finished measurement yields a timing difference in clock cycles. A second machine qualifies lock from these differences. It has two states:
- `LK_HUNT`: lock is not held.
- `LK_HELD`: lock is held.

It moves from hunt to held (acquire) after a run of in-window comparisons. It moves from held to hunt (drop) on the first comparison outside the window, or when the block is disabled.

Top module: `fg_phase_cmp`

## Requirements
- R1: Right after reset, pump_up and pump_dn are 0, err_code is 2'b00 (released) and lock_n is 1.
- R2: If the reference falls d≥1 cycles before the feedback, pump_up is high for exactly d consecutive cycles. During that time pump_dn is 0 and err_code is 2'b01 (source).
- R3: If the feedback falls d≥1 cycles before the reference, pump_dn is high for exactly d consecutive cycles. During that time pump_up is 0 and err_code is 2'b10 (sink). Outside pulses err_code is 2'b00, and 2'b11 never appears.
- R4: Rising edges of either input start no pulse and count as no comparison.
- R5: Falling edges of both inputs in the same cycle produce no pulse. They count as a comparison with difference 0.
- R6: With SYNC_STAGES=2, the leading pump output is still low at the second falling clock edge after the input falls. It is high at the third.
- R7: A second reference fall before the feedback fall (or a second feedback fall before the reference fall) keeps the running pulse high without a gap. It counts as an out-of-window comparison, so lock is dropped, and the difference is re-measured from the second edge.
- R8: lock_n goes to 0 after LOCK_K (default 4) consecutive comparisons whose difference in cycles is at most win_cyc.
- R9: The first comparison whose difference exceeds win_cyc sets lock_n back to 1 and restarts the run count.
- R10: While en is 0, from the next clock on, pump_up and pump_dn are 0 and lock_n is 1. Edges arriving meanwhile produce no pulse and no comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Comparator enable |
| ref_in | input | 1 | Asynchronous reference clock |
| fb_in | input | 1 | Asynchronous motor speed feedback |
| win_cyc | input | CNT_W | Lock window in clock cycles (inclusive) |
| pump_up | output | 1 | Motor lags: speed up |
| pump_dn | output | 1 | Motor leads: slow down |
| err_code | output | 2 | 00 released, 01 source, 10 sink |
| lock_n | output | 1 | Active-low raw lock flag |

## Verification
Pulses are produced with the reference leading and with the feedback leading, at several offsets. This separates the up and down paths and proves that width tracks offset cycle for cycle. Coincident falls and staggered rises show that only falling edges matter and that a zero difference still counts toward lock. A double reference fall exercises the slip path. In that case the pulse must continue while lock drops. The window is changed between runs so that the same offset is in window at one setting and out at another, and acquire and drop are observed on both sides of the inclusive bound. A disabled interval, entered while locked, shows the outputs going quiet and lock clearing.

// File: rtl/pc_pkg.sv
package pc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LAG  = 2'b01,
        PH_LEAD = 2'b10
    } ph_state_t;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lk_state_t;

    localparam logic [1:0] ERR_HIZ = 2'b00;
    localparam logic [1:0] ERR_SRC = 2'b01;
    localparam logic [1:0] ERR_SNK = 2'b10;

endpackage

// File: rtl/pc_fall_det.sv
module pc_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    // sh[0..STAGES-1] synchronize, sh[STAGES] holds the previous synced value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= din;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_chain
        always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1];
        end
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/pc_pump_fsm.sv
module pc_pump_fsm
    import pc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_fall,
    input  logic             fb_fall,
    output logic             pump_up,
    output logic             pump_dn,
    output logic [1:0]       err_code,
    output logic             cmp_valid,
    output logic [CNT_W-1:0] cmp_diff
);
    localparam logic [CNT_W-1:0] SPAN_MAX = '1;
    localparam logic [CNT_W-1:0] SPAN_ONE = CNT_W'(1);

    ph_state_t        state_q, state_d;
    logic [CNT_W-1:0] span_q, span_d;
    logic             restart;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            span_q  <= '0;
        end else begin
            state_q <= state_d;
            span_q  <= span_d;
        end
    end

    // transitions and comparison events
    always_comb begin
        state_d   = state_q;
        cmp_valid = 1'b0;
        cmp_diff  = '0;
        restart   = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (ref_fall && fb_fall) begin
                    cmp_valid = 1'b1;              // coincide
                end else if (ref_fall) begin
                    state_d = PH_LAG;              // start-lag
                    restart = 1'b1;
                end else if (fb_fall) begin
                    state_d = PH_LEAD;             // start-lead
                    restart = 1'b1;
                end
            end
            PH_LAG: begin
                if (fb_fall) begin
                    cmp_valid = 1'b1;
                    cmp_diff  = span_q;
                    if (ref_fall) restart = 1'b1;  // close-and-reopen
                    else          state_d = PH_IDLE; // close
                end else if (ref_fall) begin
                    cmp_valid = 1'b1;              // slip
                    cmp_diff  = SPAN_MAX;
                    restart   = 1'b1;
                end
            end
            PH_LEAD: begin
                if (ref_fall) begin
                    cmp_valid = 1'b1;
                    cmp_diff  = span_q;
                    if (fb_fall) restart = 1'b1;
                    else         state_d = PH_IDLE;
                end else if (fb_fall) begin
                    cmp_valid = 1'b1;
                    cmp_diff  = SPAN_MAX;
                    restart   = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
        if (!en) begin                             // halt
            state_d   = PH_IDLE;
            cmp_valid = 1'b0;
            restart   = 1'b0;
        end
    end

    // span counter, saturating
    always_comb begin
        if (restart)                 span_d = SPAN_ONE;
        else if (state_d == PH_IDLE) span_d = '0;
        else if (span_q == SPAN_MAX) span_d = SPAN_MAX;
        else                         span_d = span_q + SPAN_ONE;
    end

    // outputs
    always_comb begin
        pump_up  = 1'b0;
        pump_dn  = 1'b0;
        err_code = ERR_HIZ;
        unique case (state_q)
            PH_LAG: begin
                pump_up  = 1'b1;
                err_code = ERR_SRC;
            end
            PH_LEAD: begin
                pump_dn  = 1'b1;
                err_code = ERR_SNK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pc_lock_qual.sv
module pc_lock_qual
    import pc_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int LOCK_K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cmp_valid,
    input  logic [CNT_W-1:0] cmp_diff,
    input  logic [CNT_W-1:0] win_cyc,
    output logic             cmp_hit,
    output logic             lock_n
);
    localparam int          RUN_W    = $clog2(LOCK_K + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_K - 1);

    lk_state_t        state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;

    assign cmp_hit = (cmp_diff <= win_cyc);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_HUNT;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            LK_HUNT: begin
                if (cmp_valid && cmp_hit) begin
                    if (run_q == RUN_LAST) begin
                        state_d = LK_HELD;         // acquire
                        run_d   = '0;
                    end else begin
                        run_d = run_q + RUN_W'(1);
                    end
                end else if (cmp_valid) begin
                    run_d = '0;
                end
            end
            LK_HELD: begin
                if (cmp_valid && !cmp_hit) state_d = LK_HUNT; // drop
            end
            default: state_d = LK_HUNT;
        endcase
        if (!en) begin
            state_d = LK_HUNT;
            run_d   = '0;
        end
    end

    // outputs
    always_comb begin
        lock_n = 1'b1;
        unique case (state_q)
            LK_HELD: lock_n = 1'b0;
            default: lock_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/fg_phase_cmp.sv
module fg_phase_cmp
    import pc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 12,
    parameter int LOCK_K      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] win_cyc,
    output logic             pump_up,
    output logic             pump_dn,
    output logic [1:0]       err_code,
    output logic             lock_n
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] falls;
    logic            ref_fall, fb_fall;
    logic            cmp_valid, cmp_hit;
    logic [CNT_W-1:0] cmp_diff;

    assign raw_in = {fb_in, ref_in};

    for (genvar i = 0; i < N_IN; i++) begin : g_edge
        pc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .fall (falls[i])
        );
    end

    assign ref_fall = falls[0];
    assign fb_fall  = falls[1];

    pc_pump_fsm #(.CNT_W(CNT_W)) u_pump (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ref_fall (ref_fall),
        .fb_fall  (fb_fall),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .err_code (err_code),
        .cmp_valid(cmp_valid),
        .cmp_diff (cmp_diff)
    );

    pc_lock_qual #(.CNT_W(CNT_W), .LOCK_K(LOCK_K)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cmp_valid(cmp_valid),
        .cmp_diff (cmp_diff),
        .win_cyc  (win_cyc),
        .cmp_hit  (cmp_hit),
        .lock_n   (lock_n)
    );
endmodule

// File: rtl/pc_checker.sv
module pc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       ref_fall,
    input logic       fb_fall,
    input logic       cmp_valid,
    input logic       cmp_hit,
    input logic       pump_up,
    input logic       pump_dn,
    input logic [1:0] err_code,
    input logic       lock_n
);
    p_pumps_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    p_up_sources_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pump_up |-> (err_code == 2'b01));

    p_dn_sinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dn |-> (err_code == 2'b10));

    p_no_code3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'b11);

    p_up_from_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(ref_fall));

    p_dn_from_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_dn) |-> $past(fb_fall));

    p_lock_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(cmp_valid && cmp_hit && en));

    p_miss_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_hit) |=> lock_n);

    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pump_up && !pump_dn && lock_n));
endmodule

bind fg_phase_cmp pc_checker u_pc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ref_fall (ref_fall),
    .fb_fall  (fb_fall),
    .cmp_valid(cmp_valid),
    .cmp_hit  (cmp_hit),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .err_code (err_code),
    .lock_n   (lock_n)
);

// File: tb/test_fg_phase_cmp.sv
`timescale 1ns/1ps
module test_fg_phase_cmp;
    localparam int CNT_W  = 12;
    localparam int LOCK_K = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1;
    logic             ref_in = 1'b1;
    logic             fb_in = 1'b1;
    logic [CNT_W-1:0] win_cyc = CNT_W'(3);
    logic             pump_up, pump_dn, lock_n;
    logic [1:0]       err_code;

    always #2 clk = ~clk;

    fg_phase_cmp #(.SYNC_STAGES(2), .CNT_W(CNT_W), .LOCK_K(LOCK_K)) i_fg_phase_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in), .fb_in(fb_in),
        .win_cyc(win_cyc), .pump_up(pump_up), .pump_dn(pump_dn),
        .err_code(err_code), .lock_n(lock_n)
    );

    typedef struct {
        bit    up;
        int    width;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    good   = 0;   // bench lock model: consecutive in-window comparisons
    int    up_len = 0;
    int    dn_len = 0;
    bit    code_bad = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic close_pulse(bit up, int w);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R4 unexpected %s pulse actual=%0d expected=0",
                     up ? "up" : "down", w);
        end else begin
            e = exp_q.pop_front();
            if (e.up != up || e.width != w || code_bad) begin
                fails++;
                $display("FAIL %s pulse dir/width/code actual=%0d/%0d/%0d expected=%0d/%0d/0",
                         e.tag, up, w, code_bad, e.up, e.width);
            end
        end
        code_bad = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            up_len = 0; dn_len = 0; code_bad = 0;
        end else begin
            if (pump_up) begin
                up_len++;
                if (err_code != 2'b01 || pump_dn) code_bad = 1;
            end else if (up_len > 0) begin
                close_pulse(1'b1, up_len);
                up_len = 0;
            end
            if (pump_dn) begin
                dn_len++;
                if (err_code != 2'b10 || pump_up) code_bad = 1;
            end else if (dn_len > 0) begin
                close_pulse(1'b0, dn_len);
                dn_len = 0;
            end
            if (!pump_up && !pump_dn && err_code != 2'b00) code_bad = 1;
        end
    end

    task automatic raise_both();
        bit quiet = 1;
        @(negedge clk) ref_in = 1'b1;
        repeat (4) @(negedge clk);
        fb_in = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (pump_up || pump_dn) quiet = 0;
        end
        chk(quiet, "R4", "pump on rising edges", !quiet, 0);
    endtask

    task automatic check_lock();
        bit exp_lock = (good >= LOCK_K);
        chk(lock_n == !exp_lock, exp_lock ? "R8" : "R9", "lock_n", lock_n, !exp_lock);
    endtask

    // one falling pair: leader falls, follower d cycles later
    task automatic pair(bit lead_ref, int d, bit active);
        bit l2 = 0, l3 = 0, any3 = 0;
        raise_both();
        if (active && d > 0) exp_q.push_back('{lead_ref, d, lead_ref ? "R2" : "R3"});
        @(negedge clk);
        if (lead_ref || d == 0) ref_in = 1'b0;
        if (!lead_ref || d == 0) fb_in = 1'b0;
        for (int k = 1; k <= d + 8; k++) begin
            @(negedge clk);
            if (k == 2) l2 = lead_ref ? pump_up : pump_dn;
            if (k == 3) begin
                l3   = lead_ref ? pump_up : pump_dn;
                any3 = pump_up || pump_dn;
            end
            if (k == d) begin
                if (lead_ref) fb_in = 1'b0;
                else          ref_in = 1'b0;
            end
        end
        if (!active)
            chk(!any3, "R10", "pump while disabled", any3, 0);
        else if (d == 0)
            chk(!any3, "R5", "pump on coincident falls", any3, 0);
        else
            chk(!l2 && l3, "R6", "latency lead pump at 2nd/3rd edge", {l2, l3}, 1);
        if (active) begin
            if (d <= int'(win_cyc)) good++;
            else                    good = 0;
        end
        check_lock();
    endtask

    // reference falls twice before the feedback falls
    task automatic slip();
        raise_both();
        exp_q.push_back('{1'b1, 12, "R7"});
        @(negedge clk) ref_in = 1'b0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 5)  ref_in = 1'b1;
            if (k == 8)  ref_in = 1'b0;
            if (k == 12) fb_in  = 1'b0;
        end
        good = 0;                     // slip is out of window
        if (4 <= int'(win_cyc)) good++;
        chk(lock_n == 1'b1, "R7", "lock_n after slip", lock_n, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pump_up && !pump_dn, "R1", "pumps after reset", {pump_up, pump_dn}, 0);
        chk(err_code == 2'b00, "R1", "err_code after reset", err_code, 0);
        chk(lock_n == 1'b1, "R1", "lock_n after reset", lock_n, 1);

        for (int i = 0; i < 4; i++) pair(1'b1, 2, 1'b1);   // acquire on 4th
        pair(1'b0, 3, 1'b1);                               // inclusive bound
        pair(1'b1, 7, 1'b1);                               // drop
        for (int i = 0; i < 4; i++) pair(1'b1, 0, 1'b1);   // coincident falls lock
        slip();
        win_cyc = CNT_W'(10);
        for (int i = 0; i < 4; i++) pair(1'b1, 7, 1'b1);   // same offset now in window
        pair(1'b0, 10, 1'b1);
        pair(1'b0, 11, 1'b1);
        pair(1'b0, 5, 1'b1);
        for (int i = 0; i < 3; i++) pair(1'b1, 1, 1'b1);   // relock
        @(negedge clk) en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!pump_up && !pump_dn && lock_n, "R10", "quiet after disable",
            {pump_up, pump_dn, lock_n}, 1);
        good = 0;
        pair(1'b1, 5, 1'b0);
        @(negedge clk) en = 1'b1;
        pair(1'b1, 3, 1'b1);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "missing pulses", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule